// File: doc/BRIEF.md
# I2C Byte Master

This block is a single-master I2C engine that software steps through a transfer one bus phase at a time. Software sets bits in a control register to request a START, a STOP or the next byte. The engine performs that phase on open-drain SCL and SDA lines and then raises an event flag. While the flag is raised the bus is frozen with SCL held low. An 8-bit status code reports which phase finished and how the receiver answered.

Software loads the data register with a 7-bit address plus a direction bit, or with a payload byte, and clears the flag to release the engine. A received byte appears in the same data register. A clock register chooses the bit rate: every SCL period lasts ten prescaler ticks, and one tick is `(M+1)·2^N` input clocks. A one-shot soft-reset register abandons any transfer and releases both lines. A line-state register shows the levels on the pins and what the engine is driving.

The register offsets are: 0 control, 1 status (read only), 2 data, 3 clock, 4 soft reset, 5 line state (read only).

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the registers read as follows: control 0x00, status 0xF8, data 0x00, clock 0x28 (M=5, N=0), soft reset 0x00, and line state 0x3A while both lines are high. irq is 0.
- R2: Control bit positions are 7 event-interrupt enable, 6 bus enable, 5 START, 4 STOP, 3 event flag, 2 ACK. Writing 0 to bit 3 clears the event flag. Writing 1 to bit 3 never sets it.
- R3: With the bus enabled, a START request from idle produces a start condition. The flag is then set, status reads 0x08, and the START bit clears. With the bus disabled, START is ignored: status stays 0xF8 and the flag stays 0.
- R4: Transmitted bytes go out MSB first. An address with direction bit 0 gives status 0x18 when acknowledged and 0x20 when not. A data byte gives 0x28 when acknowledged and 0x30 when not.
- R5: A START requested while the bus is held produces a repeated start with status 0x10. An address with direction bit 1 then gives 0x40 when acknowledged and 0x48 when not.
- R6: In a read byte the engine answers ACK when control bit 2 is 1 (status 0x50) and NACK when it is 0 (status 0x58). The received byte, MSB first, is then readable in the data register.
- R7: While the event flag is set, SCL stays driven low and neither line changes. irq equals the enable bit AND the flag.
- R8: A STOP request produces a stop condition, and the STOP bit then clears by itself. Status returns to 0xF8, the flag stays 0, and line state reads 0x3A.
- R9: A byte request made after status 0x20, 0x30, 0x48 or 0x58 sets status 0x00 and sets the flag again, with no bus activity. Only START or STOP proceed from those states.
- R10: The clock register holds M in bits [6:3] and N in bits [2:0]. The SCL period is 10·(M+1)·2^N input clocks.
- R11: Writing 1 to bit 0 of the soft-reset register aborts any transfer. Both lines are released, START, STOP and the flag clear, status reads 0xF8, and the bit reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe for reg_addr |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq | output | 1 | Event interrupt |
| scl_i | input | 1 | Sensed SCL level |
| scl_lo | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | Sensed SDA level |
| sda_lo | output | 1 | 1 pulls SDA low |

## Verification
A register write takes effect at the next clock edge. The start condition completes ten prescaler ticks after the request. A byte with its acknowledge slot takes ninety ticks, and a stop condition takes ten. The event flag rises one clock after each phase ends, and a soft reset takes effect in one clock. Because these latencies scale with the divider, the bench does not wait a fixed count. It polls the control register until the flag or the STOP bit changes, then reads the status, data and line registers. Fixed waits are used only for the checks that nothing happens: the disabled START, the held bus, and the rejected byte request.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [7:0] {
        SC_BUSERR  = 8'h00,
        SC_START   = 8'h08,
        SC_RESTART = 8'h10,
        SC_AW_ACK  = 8'h18,
        SC_AW_NACK = 8'h20,
        SC_TX_ACK  = 8'h28,
        SC_TX_NACK = 8'h30,
        SC_AR_ACK  = 8'h40,
        SC_AR_NACK = 8'h48,
        SC_RX_ACK  = 8'h50,
        SC_RX_NACK = 8'h58,
        SC_IDLE    = 8'hF8
    } stat_e;

    typedef enum logic [2:0] {EG_IDLE, EG_HOLD, EG_START, EG_XFER, EG_STOP} eng_e;

    typedef enum logic [1:0] {BK_ADDR, BK_TX, BK_RX} byte_e;

    typedef struct packed {
        logic int_en;
        logic bus_en;
        logic start;
        logic stop;
        logic flag;
        logic ack;
    } ctl_t;

    localparam int TICKS_PER_BIT = 10;
    localparam int BITS_PER_SLOT = 9;

    localparam logic [2:0] RA_CTL  = 3'd0;
    localparam logic [2:0] RA_STAT = 3'd1;
    localparam logic [2:0] RA_DATA = 3'd2;
    localparam logic [2:0] RA_CLK  = 3'd3;
    localparam logic [2:0] RA_SRST = 3'd4;
    localparam logic [2:0] RA_LINE = 3'd5;

    function automatic stat_e byte_status(byte_e k, logic rw, logic ack);
        case (k)
            BK_ADDR: return rw ? (ack ? SC_AR_ACK : SC_AR_NACK)
                               : (ack ? SC_AW_ACK : SC_AW_NACK);
            BK_TX:   return ack ? SC_TX_ACK : SC_TX_NACK;
            default: return ack ? SC_RX_ACK : SC_RX_NACK;
        endcase
    endfunction

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int MW = 4,
    parameter int NW = 3,
    parameter int CW = MW + (1 << NW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [MW-1:0] div_m,
    input  logic [NW-1:0] div_n,
    output logic          tick
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit = (CW'(div_m) + CW'(1)) << div_n;
    assign tick  = (cnt >= limit - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       flag,
    input  logic       bus_en,
    input  logic       start_req,
    input  logic       stop_req,
    input  logic       ack_en,
    input  logic [7:0] tx_byte,
    input  logic       sda_i,
    output logic       scl_lo,
    output logic       sda_lo,
    output logic       ev_flag,
    output logic       ev_start_done,
    output logic       ev_stop_done,
    output logic       rx_load,
    output logic [7:0] rx_byte,
    output stat_e      status
);
    localparam logic [3:0] LAST_T   = 4'(TICKS_PER_BIT - 1);
    localparam logic [3:0] ACK_SLOT = 4'(BITS_PER_SLOT - 1);

    eng_e       st;
    byte_e      kind;
    logic [3:0] t, bitn;
    logic [7:0] sh;
    logic       from_hold, ack_got, ack_sent, drive_low;

    assign rx_byte = sh;

    always_comb begin
        if (bitn < ACK_SLOT) drive_low = (kind != BK_RX) && !sh[7];
        else                 drive_low = (kind == BK_RX) && ack_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= EG_IDLE;  kind <= BK_ADDR;  t <= '0;  bitn <= '0;  sh <= '0;
            from_hold <= 1'b0;  ack_got <= 1'b0;  ack_sent <= 1'b0;
            scl_lo <= 1'b0;  sda_lo <= 1'b0;  status <= SC_IDLE;
            ev_flag <= 1'b0;  ev_start_done <= 1'b0;  ev_stop_done <= 1'b0;  rx_load <= 1'b0;
        end else begin
            ev_flag <= 1'b0;  ev_start_done <= 1'b0;  ev_stop_done <= 1'b0;  rx_load <= 1'b0;
            if (tick && (st == EG_START || st == EG_XFER || st == EG_STOP))
                t <= (t == LAST_T) ? 4'd0 : t + 4'd1;
            case (st)
                EG_IDLE: if (bus_en && start_req && !flag) begin
                    st <= EG_START;  from_hold <= 1'b0;  t <= '0;
                end
                EG_HOLD: if (!flag && !ev_flag) begin
                    t <= '0;  bitn <= '0;
                    if (start_req) begin
                        st <= EG_START;  from_hold <= 1'b1;
                    end else if (stop_req) begin
                        st <= EG_STOP;
                    end else begin
                        case (status)
                            SC_START, SC_RESTART: begin kind <= BK_ADDR; sh <= tx_byte; st <= EG_XFER; end
                            SC_AW_ACK, SC_TX_ACK: begin kind <= BK_TX;   sh <= tx_byte; st <= EG_XFER; end
                            SC_AR_ACK, SC_RX_ACK: begin kind <= BK_RX;   sh <= '0;      st <= EG_XFER; end
                            default:              begin status <= SC_BUSERR; ev_flag <= 1'b1; end
                        endcase
                    end
                end
                EG_START: if (tick) begin
                    case (t)
                        4'd0: scl_lo <= 1'b1;
                        4'd1: sda_lo <= 1'b0;
                        4'd3: scl_lo <= 1'b0;
                        4'd6: sda_lo <= 1'b1;
                        LAST_T: begin
                            scl_lo <= 1'b1;  st <= EG_HOLD;  ev_flag <= 1'b1;  ev_start_done <= 1'b1;
                            status <= from_hold ? SC_RESTART : SC_START;
                        end
                        default: ;
                    endcase
                end
                EG_XFER: if (tick) begin
                    case (t)
                        4'd1: begin
                            sda_lo <= drive_low;
                            if (bitn == ACK_SLOT) ack_sent <= ack_en;
                        end
                        4'd5: scl_lo <= 1'b0;
                        4'd7: begin
                            if (bitn == ACK_SLOT) ack_got <= !sda_i;
                            else                  sh <= {sh[6:0], sda_i};
                        end
                        LAST_T: begin
                            scl_lo <= 1'b1;
                            if (bitn == ACK_SLOT) begin
                                st <= EG_HOLD;  ev_flag <= 1'b1;
                                status  <= byte_status(kind, sh[0], (kind == BK_RX) ? ack_sent : ack_got);
                                rx_load <= (kind == BK_RX);
                            end else begin
                                bitn <= bitn + 4'd1;
                            end
                        end
                        default: ;
                    endcase
                end
                EG_STOP: if (tick) begin
                    case (t)
                        4'd1: sda_lo <= 1'b1;
                        4'd5: scl_lo <= 1'b0;
                        4'd8: sda_lo <= 1'b0;
                        LAST_T: begin st <= EG_IDLE; status <= SC_IDLE; ev_stop_done <= 1'b1; end
                        default: ;
                    endcase
                end
                default: st <= EG_IDLE;
            endcase
        end
    end

    // R4
    sda_setup_chk: assert property (@(posedge clk) disable iff (rst)
        (st == EG_XFER && !$stable(sda_lo)) |-> scl_lo);
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int         DIV_M_W   = 4,
    parameter int         DIV_N_W   = 3,
    parameter logic [7:0] CLK_RESET = 8'h28
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    input  logic       scl_i,
    output logic       scl_lo,
    input  logic       sda_i,
    output logic       sda_lo
);
    localparam int CLK_W = DIV_M_W + DIV_N_W;
    localparam int CNT_W = DIV_M_W + (1 << DIV_N_W);

    ctl_t             ctl;
    logic [7:0]       data_q, rx_byte;
    logic [CLK_W-1:0] clk_q;
    logic             srst_q, tick, ev_flag, ev_start_done, ev_stop_done, rx_load;
    stat_e            status;

    wire eng_rst = rst || srst_q;
    wire wr_ctl  = reg_wr && (reg_addr == RA_CTL);
    wire wr_data = reg_wr && (reg_addr == RA_DATA);
    wire wr_clk  = reg_wr && (reg_addr == RA_CLK);
    wire wr_srst = reg_wr && (reg_addr == RA_SRST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (srst_q) begin
            ctl.start <= 1'b0;  ctl.stop <= 1'b0;  ctl.flag <= 1'b0;
        end else begin
            if (wr_ctl) begin
                ctl.int_en <= reg_wdata[7];
                ctl.bus_en <= reg_wdata[6];
                ctl.start  <= reg_wdata[5];
                ctl.stop   <= reg_wdata[4];
                ctl.ack    <= reg_wdata[2];
                if (!reg_wdata[3]) ctl.flag <= 1'b0;
            end
            if (ev_flag)       ctl.flag  <= 1'b1;
            if (ev_start_done) ctl.start <= 1'b0;
            if (ev_stop_done)  ctl.stop  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;  clk_q <= CLK_RESET[CLK_W-1:0];  srst_q <= 1'b0;
        end else begin
            srst_q <= wr_srst && reg_wdata[0];
            if (rx_load)      data_q <= rx_byte;
            else if (wr_data) data_q <= reg_wdata;
            if (wr_clk)       clk_q  <= reg_wdata[CLK_W-1:0];
        end
    end

    i2cm_tick #(.MW(DIV_M_W), .NW(DIV_N_W), .CW(CNT_W)) u_tick (
        .clk(clk), .rst(rst),
        .div_m(clk_q[CLK_W-1 -: DIV_M_W]), .div_n(clk_q[DIV_N_W-1:0]),
        .tick(tick)
    );

    i2cm_engine u_engine (
        .clk(clk), .rst(eng_rst), .tick(tick), .flag(ctl.flag), .bus_en(ctl.bus_en),
        .start_req(ctl.start), .stop_req(ctl.stop), .ack_en(ctl.ack), .tx_byte(data_q),
        .sda_i(sda_i), .scl_lo(scl_lo), .sda_lo(sda_lo), .ev_flag(ev_flag),
        .ev_start_done(ev_start_done), .ev_stop_done(ev_stop_done),
        .rx_load(rx_load), .rx_byte(rx_byte), .status(status)
    );

    assign irq = ctl.int_en && ctl.flag;

    always_comb begin
        case (reg_addr)
            RA_CTL:  reg_rdata = {ctl.int_en, ctl.bus_en, ctl.start, ctl.stop, ctl.flag, ctl.ack, 2'b00};
            RA_STAT: reg_rdata = status;
            RA_DATA: reg_rdata = data_q;
            RA_CLK:  reg_rdata = 8'(clk_q);
            RA_SRST: reg_rdata = {7'b0, srst_q};
            RA_LINE: reg_rdata = {2'b00, scl_i, sda_i, ~scl_lo, 1'b0, ~sda_lo, 1'b0};
            default: reg_rdata = 8'h00;
        endcase
    end

    // R7
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst || srst_q)
        (ctl.flag && $past(ctl.flag)) |-> (scl_lo && $stable(scl_lo) && $stable(sda_lo)));

    // R3
    flag_code_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.flag) |-> (status != SC_IDLE));

    // R8
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(ctl.stop) && !$past(wr_ctl) && !$past(srst_q)) |-> (status == SC_IDLE && !ctl.flag));
endmodule

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;
    logic clk = 1'b0, rst = 1'b1;
    always #10 clk = ~clk;

    logic [2:0] ra = '0;
    logic       rw = 1'b0;
    logic [7:0] wd = '0;
    wire  [7:0] rd;
    wire        irq, scl_lo_w, sda_lo_w;
    logic       slv_low = 1'b0;
    wire        scl_bus = ~scl_lo_w;
    wire        sda_bus = ~(sda_lo_w | slv_low);

    i2c_byte_master u_i2c_byte_master (
        .clk(clk), .rst(rst), .reg_addr(ra), .reg_wr(rw), .reg_wdata(wd), .reg_rdata(rd),
        .irq(irq), .scl_i(scl_bus), .scl_lo(scl_lo_w), .sda_i(sda_bus), .sda_lo(sda_lo_w)
    );

    // Target model at address 0x50; NACKs a written 0xFF; after an ACKed read byte it sends 0xFF.
    localparam logic [6:0] SLV = 7'h50;
    int         mode = 0, bitcnt = 0;
    logic       armed = 1'b0, acked = 1'b0, mack = 1'b0;
    logic [7:0] ssh = '0, txb = '0, rd_byte = '0, slv_rx = '0;

    always @(negedge sda_bus) if (scl_bus === 1'b1) begin mode = 1; bitcnt = 0; armed = 0; slv_low = 0; end
    always @(posedge sda_bus) if (scl_bus === 1'b1) begin mode = 0; slv_low = 0; end
    always @(posedge scl_bus) if (mode != 0 && armed) begin
        if (bitcnt < 8) ssh = {ssh[6:0], sda_bus}; else mack = sda_bus;
    end
    always @(negedge scl_bus) if (mode != 0) begin
        if (!armed) armed = 1;
        else begin
            bitcnt++;
            if (bitcnt == 8) begin
                if (mode == 1) begin acked = (ssh[7:1] == SLV); slv_low = acked; end
                else if (mode == 2) begin slv_rx = ssh; slv_low = (ssh != 8'hFF); end
                else slv_low = 0;
            end else if (bitcnt == 9) begin
                bitcnt = 0; slv_low = 0;
                if (mode == 1) begin
                    if (!acked) mode = 0;
                    else if (ssh[0]) begin mode = 3; txb = rd_byte; slv_low = ~txb[7]; end
                    else mode = 2;
                end else if (mode == 3) begin
                    if (mack) mode = 0; else begin txb = 8'hFF; slv_low = 0; end
                end
            end else if (mode == 3) slv_low = ~txb[7-bitcnt];
        end
    end

    int checks = 0, errors = 0;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); ra = a; wd = d; rw = 1'b1;
        @(negedge clk); rw = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); ra = a; #1; v = rd;
    endtask

    task automatic wait_ctl(input string tag, input int bitpos, input logic lvl);
        logic [7:0] v;
        for (int i = 0; i < 6000; i++) begin
            rd_reg(3'd0, v);
            if (v[bitpos] == lvl) return;
        end
        check({tag, " wait"}, v, v ^ (8'h1 << bitpos));
    endtask

    task automatic step(input logic [7:0] c, input string tag, input logic [7:0] exp);
        logic [7:0] v;
        wr_reg(3'd0, c);
        wait_ctl(tag, 3, 1'b1);
        rd_reg(3'd1, v);
        check(tag, v, exp);
    endtask

    task automatic do_stop(input logic [7:0] c);
        logic [7:0] v;
        wr_reg(3'd0, c);
        wait_ctl("R8 stop", 4, 1'b0);
        rd_reg(3'd1, v); check("R8 status after stop", v, 8'hF8);
        rd_reg(3'd5, v); check("R8 lines after stop", v, 8'h3A);
    endtask

    // {read, addr7, byte, ack bit, status after address, status after byte}
    localparam logic [47:0] VEC [6] = '{
        {8'h00, 8'h50, 8'hA5, 8'h00, 8'h18, 8'h28},
        {8'h00, 8'h51, 8'h00, 8'h00, 8'h20, 8'h00},
        {8'h00, 8'h50, 8'hFF, 8'h00, 8'h18, 8'h30},
        {8'h01, 8'h50, 8'h3C, 8'h01, 8'h40, 8'h50},
        {8'h01, 8'h50, 8'hC3, 8'h00, 8'h40, 8'h58},
        {8'h01, 8'h22, 8'h00, 8'h00, 8'h48, 8'h00}
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, l1, l2;
        logic [47:0] vec;
        realtime t1, t2;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd_reg(3'd0, v); check("R1 ctl", v, 8'h00);
        rd_reg(3'd1, v); check("R1 status", v, 8'hF8);
        rd_reg(3'd2, v); check("R1 data", v, 8'h00);
        rd_reg(3'd3, v); check("R1 clk", v, 8'h28);
        rd_reg(3'd4, v); check("R1 srst", v, 8'h00);
        rd_reg(3'd5, v); check("R1 lines", v, 8'h3A);
        check("R1 irq", {7'b0, irq}, 8'h00);
        wr_reg(3'd3, 8'h00);

        // R2 flag cannot be set by software; ACK bit position
        wr_reg(3'd0, 8'h48); rd_reg(3'd0, v); check("R2 flag write-1", v, 8'h40);
        wr_reg(3'd0, 8'h44); rd_reg(3'd0, v); check("R2 ack bit", v, 8'h44);

        // R3 START ignored with bus disabled
        wr_reg(3'd0, 8'h20); repeat (200) @(posedge clk);
        rd_reg(3'd1, v); check("R3 disabled status", v, 8'hF8);
        rd_reg(3'd0, v); check("R3 disabled ctl", v, 8'h20);
        wr_reg(3'd0, 8'h00);

        for (int i = 0; i < 6; i++) begin
            vec = VEC[i];
            rd_byte = vec[31:24];
            wr_reg(3'd2, {vec[38:32], vec[40]});
            step(8'hE0, "R3 start", 8'h08);
            check("R7 irq", {7'b0, irq}, 8'h01);
            rd_reg(3'd0, v); check("R3 start bit clear", v & 8'h20, 8'h00);
            step(8'hC0, "R4/R5 address", vec[15:8]);
            if (vec[15:8] == 8'h18) begin
                wr_reg(3'd2, vec[31:24]);
                step(8'hC0, "R4 data byte", vec[7:0]);
                if (vec[7:0] == 8'h28) check("R4 byte on bus", slv_rx, vec[31:24]);
            end else if (vec[15:8] == 8'h40) begin
                step(8'hC0 | {5'b0, vec[16], 2'b0}, "R6 read byte", vec[7:0]);
                rd_reg(3'd2, v); check("R6 received", v, vec[31:24]);
            end
            do_stop(8'hD0);
            rd_reg(3'd0, v); check("R8 ctl after stop", v, 8'hC0);
        end

        // R5 repeated start, R6 NACK read, R9 rejected byte request
        wr_reg(3'd2, 8'hA0); rd_byte = 8'h5A;
        step(8'hE0, "R3 start", 8'h08);
        step(8'hC0, "R4 address write", 8'h18);
        step(8'hE0, "R5 restart", 8'h10);
        wr_reg(3'd2, 8'hA1);
        step(8'hC0, "R5 address read", 8'h40);
        step(8'hC0, "R6 nack read", 8'h58);
        rd_reg(3'd2, v); check("R6 received", v, 8'h5A);
        rd_reg(3'd5, l1);
        step(8'hC0, "R9 bus error", 8'h00);
        rd_reg(3'd5, l2); check("R9 lines untouched", l2, l1);
        do_stop(8'hD0);

        // R7 bus held, irq masked
        wr_reg(3'd2, 8'hA0);
        wr_reg(3'd0, 8'h60); wait_ctl("R7 start", 3, 1'b1);
        check("R7 irq masked", {7'b0, irq}, 8'h00);
        rd_reg(3'd5, l1); repeat (100) @(posedge clk); rd_reg(3'd5, l2);
        check("R7 lines frozen", l2, l1);
        check("R7 scl low", l2 & 8'h20, 8'h00);
        do_stop(8'h50);

        // R10 divider M=1 N=1 -> 40 clocks per SCL period
        wr_reg(3'd3, 8'h09); rd_reg(3'd3, v); check("R10 clk reg", v, 8'h09);
        wr_reg(3'd2, 8'hA0);
        step(8'hE0, "R3 start", 8'h08);
        wr_reg(3'd0, 8'hC0);
        @(posedge scl_bus) t1 = $realtime;
        @(posedge scl_bus) t2 = $realtime;
        check("R10 scl period", 8'(int'((t2 - t1) / 20.0)), 8'd40);
        wait_ctl("R10 byte", 3, 1'b1);
        rd_reg(3'd1, v); check("R10 status", v, 8'h18);
        do_stop(8'hD0);
        wr_reg(3'd3, 8'h00);

        // R11 soft reset mid-byte
        wr_reg(3'd2, 8'hA0);
        step(8'hE0, "R3 start", 8'h08);
        wr_reg(3'd0, 8'hC0);
        repeat (35) @(posedge clk);
        wr_reg(3'd4, 8'h01); repeat (3) @(posedge clk);
        rd_reg(3'd1, v); check("R11 status", v, 8'hF8);
        rd_reg(3'd0, v); check("R11 ctl", v, 8'hC0);
        rd_reg(3'd5, v); check("R11 lines", v, 8'h3A);
        rd_reg(3'd4, v); check("R11 self clear", v, 8'h00);
        step(8'hE0, "R11 restart after reset", 8'h08);
        step(8'hC0, "R11 address after reset", 8'h18);
        do_stop(8'hD0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule